// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block maps a 64-bit address seen on the system bus side onto a 64-bit address on the PCIe side. It holds a table of programmable outbound windows. Each window has a bus-side base address, a size code, a PCIe target address, a count of low address bits copied through unchanged, and a 23-bit transaction attribute descriptor. The descriptor carries the execute-permission, privileged-mode, PASID value and PASID-present bits.

Software programs the table through a flat register port with an address, write data and a write strobe. Each window takes a 0x20-byte slice of that space, and reads return the stored contents. One lookup address enters every cycle. One clock edge later the block presents a hit flag, the index of the winning window, the translated address and that window's descriptor.

Top module: `atu_ob_xlate`

## Requirements
- R1: After reset every stored field reads as zero, and the lookup outputs (hit, region index, address, descriptor) are zero.
- R2: Window r occupies register offsets r*0x20 upward. The word is selected by regAddr[4:2] and regAddr[1:0] are ignored. Word 0 holds base bits 31:8 in data bits 31:8 and the size code in bits 5:0. Word 1 holds base bits 63:32. Word 2 holds target bits 31:8 in data bits 31:8 and the pass-through code in bits 5:0. Word 3 holds target bits 63:32. Word 4 holds the descriptor in bits 22:0. A write is visible on a read of the same word in the next cycle.
- R3: Bits 7:6 of words 0 and 2 and bits 31:23 of word 4 are not stored and read as zero. Words 5, 6 and 7 of each window store nothing and read as zero.
- R4: With size code s, an address hits a window when address bits 63:(s+1) equal the window base at the same positions. Base bits 7:0 count as zero.
- R5: A window whose base (both words) and size code are all zero never hits.
- R6: When several windows hit, the one with the lowest index wins.
- R7: With pass-through code p, the output address equals the target address (bits 7:0 taken as zero) with its low p+1 bits replaced by the same bits of the lookup address.
- R8: On a miss the hit flag, region index, address and descriptor outputs are all zero.
- R9: The outputs reflect the lookup address sampled at the previous rising clock edge, with one cycle of latency.
- R10: On a hit the descriptor output equals the stored descriptor of the winning window.
- R11: A size code of 63 makes a window match every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | log2(NUM_REGIONS)+5 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| lookupAddr | input | 64 | Bus-side address to translate |
| outHit | output | 1 | A window matched the previous address |
| outRegion | output | log2(NUM_REGIONS) | Index of the winning window |
| outAddr | output | 64 | Translated PCIe-side address |
| outDesc | output | 23 | Descriptor of the winning window |

## Verification
The hardest cases are the window edges for every size code. Each of the 64 codes places the hit boundary at a different bit, and the matching rule changes at codes below 7, where address bits under the 8-bit base granularity must also be zero. The stimulus programs a single window and sweeps all 64 size codes. For each code it probes the base, the base with bit s flipped (inside the window) and the base with bit s+1 flipped (outside). It then sweeps all 64 pass-through codes on a window that matches everything. Overlapping windows and a zero-programmed window cover the priority and disable rules.

// File: rtl/atu_ob_pkg.sv
package atu_ob_pkg;
  localparam int AW     = 64;
  localparam int DESC_W = 23;

  typedef enum logic [2:0] {
    W_BLO  = 3'd0,
    W_BHI  = 3'd1,
    W_TLO  = 3'd2,
    W_THI  = 3'd3,
    W_DESC = 3'd4,
    W_NONE = 3'd7
  } wordSel_t;

  typedef struct packed {
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrTgtLo;
    logic wrTgtHi;
    logic wrDesc;
  } wrStrobes_t;
endpackage

// File: rtl/atu_ob_ctrl.sv
module atu_ob_ctrl
  import atu_ob_pkg::*;
#(
  parameter int NUM_REGIONS = 32,
  localparam int RIDX_W = $clog2(NUM_REGIONS),
  localparam int REG_AW = RIDX_W + 5
) (
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output wrStrobes_t        strb,
  output logic [RIDX_W-1:0] regionSel,
  output wordSel_t          wordSel
);
  logic regionOk;

  assign regionSel = regAddr[REG_AW-1:5];
  assign regionOk  = int'(regAddr[REG_AW-1:5]) < NUM_REGIONS;

  always_comb begin
    wordSel = W_NONE;
    if (regionOk) begin
      case (regAddr[4:2])
        3'd0:    wordSel = W_BLO;
        3'd1:    wordSel = W_BHI;
        3'd2:    wordSel = W_TLO;
        3'd3:    wordSel = W_THI;
        3'd4:    wordSel = W_DESC;
        default: wordSel = W_NONE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrBaseLo = regWe && (wordSel == W_BLO);
    strb.wrBaseHi = regWe && (wordSel == W_BHI);
    strb.wrTgtLo  = regWe && (wordSel == W_TLO);
    strb.wrTgtHi  = regWe && (wordSel == W_THI);
    strb.wrDesc   = regWe && (wordSel == W_DESC);
  end
endmodule

// File: rtl/atu_ob_datapath.sv
module atu_ob_datapath
  import atu_ob_pkg::*;
#(
  parameter int NUM_REGIONS = 32,
  localparam int RIDX_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strb,
  input  logic [RIDX_W-1:0] regionSel,
  input  wordSel_t          wordSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [AW-1:0]     lookupAddr,
  output logic              outHit,
  output logic [RIDX_W-1:0] outRegion,
  output logic [AW-1:0]     outAddr,
  output logic [DESC_W-1:0] outDesc
);
  localparam logic [AW-1:0] ALL1 = '1;

  logic [23:0]       baseLo   [NUM_REGIONS];
  logic [31:0]       baseHi   [NUM_REGIONS];
  logic [5:0]        sizeCode [NUM_REGIONS];
  logic [23:0]       tgtLo    [NUM_REGIONS];
  logic [31:0]       tgtHi    [NUM_REGIONS];
  logic [5:0]        passCode [NUM_REGIONS];
  logic [DESC_W-1:0] desc     [NUM_REGIONS];

  // table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        baseLo[i] <= '0; baseHi[i] <= '0; sizeCode[i] <= '0;
        tgtLo[i]  <= '0; tgtHi[i]  <= '0; passCode[i] <= '0;
        desc[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (regionSel == RIDX_W'(i)) begin
          if (strb.wrBaseLo) begin
            baseLo[i]   <= regWdata[31:8];
            sizeCode[i] <= regWdata[5:0];
          end
          if (strb.wrBaseHi) baseHi[i] <= regWdata;
          if (strb.wrTgtLo) begin
            tgtLo[i]    <= regWdata[31:8];
            passCode[i] <= regWdata[5:0];
          end
          if (strb.wrTgtHi) tgtHi[i] <= regWdata;
          if (strb.wrDesc)  desc[i]  <= regWdata[DESC_W-1:0];
        end
      end
    end
  end

  // register read mux
  always_comb begin
    regRdata = '0;
    case (wordSel)
      W_BLO:   regRdata = {baseLo[regionSel], 2'b00, sizeCode[regionSel]};
      W_BHI:   regRdata = baseHi[regionSel];
      W_TLO:   regRdata = {tgtLo[regionSel], 2'b00, passCode[regionSel]};
      W_THI:   regRdata = tgtHi[regionSel];
      W_DESC:  regRdata = {{(32-DESC_W){1'b0}}, desc[regionSel]};
      default: regRdata = '0;
    endcase
  end

  // per-window match and substitution
  logic [NUM_REGIONS-1:0] hitVec;
  logic [AW-1:0]          xlat [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    logic [AW-1:0] baseFull, tgtFull, winMask, passMask;
    logic          enabled;
    assign baseFull = {baseHi[g], baseLo[g], 8'h00};
    assign tgtFull  = {tgtHi[g], tgtLo[g], 8'h00};
    assign winMask  = ALL1 >> (6'd63 - sizeCode[g]);
    assign passMask = ALL1 >> (6'd63 - passCode[g]);
    assign enabled  = (baseFull != '0) || (sizeCode[g] != '0);
    assign hitVec[g] = enabled && (((lookupAddr ^ baseFull) & ~winMask) == '0);
    assign xlat[g]  = (tgtFull & ~passMask) | (lookupAddr & passMask);
  end

  // lowest index wins
  logic              anyHit;
  logic [RIDX_W-1:0] winIdx;
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = RIDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outHit <= 1'b0; outRegion <= '0; outAddr <= '0; outDesc <= '0;
    end else begin
      outHit    <= anyHit;
      outRegion <= anyHit ? winIdx : '0;
      outAddr   <= anyHit ? xlat[winIdx] : '0;
      outDesc   <= anyHit ? desc[winIdx] : '0;
    end
  end
endmodule

// File: rtl/atu_ob_xlate.sv
module atu_ob_xlate #(
  parameter int NUM_REGIONS = 32,
  localparam int RIDX_W = $clog2(NUM_REGIONS),
  localparam int REG_AW = RIDX_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [63:0]       lookupAddr,
  output logic              outHit,
  output logic [RIDX_W-1:0] outRegion,
  output logic [63:0]       outAddr,
  output logic [22:0]       outDesc
);
  atu_ob_pkg::wrStrobes_t strb;
  atu_ob_pkg::wordSel_t   wordSel;
  logic [RIDX_W-1:0]      regionSel;

  atu_ob_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .strb(strb),
    .regionSel(regionSel), .wordSel(wordSel)
  );

  atu_ob_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regionSel(regionSel),
    .wordSel(wordSel), .regWdata(regWdata), .regRdata(regRdata),
    .lookupAddr(lookupAddr), .outHit(outHit), .outRegion(outRegion),
    .outAddr(outAddr), .outDesc(outDesc)
  );
endmodule

// File: rtl/atu_ob_checker.sv
module atu_ob_checker #(
  parameter int NUM_REGIONS = 32,
  localparam int RIDX_W = $clog2(NUM_REGIONS),
  localparam int REG_AW = RIDX_W + 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [63:0]       lookupAddr,
  input logic              outHit,
  input logic [RIDX_W-1:0] outRegion,
  input logic [63:0]       outAddr,
  input logic [22:0]       outDesc
);
  logic addrOk;
  assign addrOk = int'(regAddr[REG_AW-1:5]) < NUM_REGIONS;

  // R8: a miss drives every result field to zero
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outHit |-> (outAddr == '0 && outRegion == '0 && outDesc == '0));

  // R7: at least the lowest address bit is always copied through
  a_r7_lsb_pass: assert property (@(posedge clk) disable iff (!rstN)
    outHit |-> (outAddr[0] == $past(lookupAddr[0])));

  // R3: unstored bits of the low words read zero
  a_r3_low_gap: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[4:2] == 3'd0 || regAddr[4:2] == 3'd2) |-> (regRdata[7:6] == 2'b00));

  // R3: descriptor upper bits and spare words read zero
  a_r3_desc_top: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[4:2] == 3'd4) |-> (regRdata[31:23] == '0));
  a_r3_spare_word: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[4:2] > 3'd4) |-> (regRdata == '0));

  // R2: a full-width high word reads back what was written
  a_r2_readback: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && addrOk && (regAddr[4:2] == 3'd1 || regAddr[4:2] == 3'd3))
      |=> ((regAddr != $past(regAddr)) || (regRdata == $past(regWdata))));
endmodule

bind atu_ob_xlate atu_ob_checker #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .lookupAddr(lookupAddr),
  .outHit(outHit), .outRegion(outRegion), .outAddr(outAddr), .outDesc(outDesc)
);

// File: tb/atu_ob_xlate_tb.sv
module atu_ob_xlate_tb;
  localparam int NR = 8;
  localparam int RW = $clog2(NR);
  localparam int AWR = RW + 5;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           regWe = 1'b0;
  logic [AWR-1:0] regAddr = '0;
  logic [31:0]    regWdata = '0;
  logic [31:0]    regRdata;
  logic [63:0]    lookupAddr = '0;
  logic           outHit;
  logic [RW-1:0]  outRegion;
  logic [63:0]    outAddr;
  logic [22:0]    outDesc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] mW [NR][5];

  atu_ob_xlate #(.NUM_REGIONS(NR)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lookupAddr(lookupAddr),
    .outHit(outHit), .outRegion(outRegion), .outAddr(outAddr), .outDesc(outDesc)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input int w, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1;
    regAddr = AWR'((r << 5) | (w << 2));
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    case (w)
      0, 2: mW[r][w] = d & 32'hFFFF_FF3F;
      1, 3: mW[r][w] = d;
      4:    mW[r][w] = d & 32'h007F_FFFF;
      default: ;
    endcase
  endtask

  task automatic rdChk(input int r, input int w, input string req);
    logic [31:0] e;
    @(negedge clk);
    regAddr = AWR'((r << 5) | (w << 2) | (w & 3));
    #1;
    e = (w < 5) ? mW[r][w] : 32'h0;
    chk(regRdata == e, req, 64'(regRdata), 64'(e));
  endtask

  task automatic cfg(input int r, input logic [63:0] b, input logic [5:0] s,
                     input logic [63:0] t, input logic [5:0] p, input logic [22:0] d);
    wr(r, 0, {b[31:8], 2'b00, s});
    wr(r, 1, b[63:32]);
    wr(r, 2, {t[31:8], 2'b00, p});
    wr(r, 3, t[63:32]);
    wr(r, 4, {9'h0, d});
  endtask

  task automatic clrAll();
    for (int r = 0; r < NR; r++) for (int w = 0; w < 5; w++) wr(r, w, 32'h0);
  endtask

  task automatic model(input logic [63:0] a, output bit h, output int idx,
                       output logic [63:0] o, output logic [22:0] d);
    h = 0; idx = 0; o = '0; d = '0;
    for (int r = NR - 1; r >= 0; r--) begin
      logic [63:0] b, t, wm, pm;
      int s, p;
      b = {mW[r][1], mW[r][0][31:8], 8'h00};
      t = {mW[r][3], mW[r][2][31:8], 8'h00};
      s = int'(mW[r][0][5:0]);
      p = int'(mW[r][2][5:0]);
      wm = (s == 63) ? '1 : ((64'd1 << (s + 1)) - 64'd1);
      pm = (p == 63) ? '1 : ((64'd1 << (p + 1)) - 64'd1);
      if (!(b == 0 && s == 0) && (((a ^ b) & ~wm) == 0)) begin
        h = 1; idx = r;
        o = (t & ~pm) | (a & pm);
        d = mW[r][4][22:0];
      end
    end
  endtask

  task automatic look(input logic [63:0] a, input int expHit, input string req);
    bit h; int idx; logic [63:0] o; logic [22:0] d;
    model(a, h, idx, o, d);
    @(negedge clk);
    lookupAddr = a;
    @(posedge clk);
    #1;
    if (expHit >= 0) chk(outHit == expHit[0], req, 64'(outHit), 64'(expHit));
    chk(outHit == h && int'(outRegion) == idx && outAddr == o && outDesc == d,
        req, outAddr, o);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) for (int w = 0; w < 5; w++) mW[r][w] = '0;
    #1;
    // R1: outputs held at zero in reset
    chk(outHit == 0 && outAddr == 0 && outDesc == 0 && outRegion == 0, "R1 reset outputs",
        outAddr, 64'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: every word reads zero
    for (int r = 0; r < NR; r++) for (int w = 0; w < 8; w++) rdChk(r, w, "R1 reset read");
    look(64'h0, 0, "R5 zero window no hit");

    // R2 / R3: read-back of patterns with reserved bits set
    for (int r = 0; r < NR; r++) begin
      for (int w = 0; w < 8; w++) wr(r, w, 32'hFFFF_FFFF ^ (32'h1111_1111 * r) ^ (w << 4));
    end
    for (int r = 0; r < NR; r++) for (int w = 0; w < 8; w++) rdChk(r, w, "R2 R3 readback");
    // R3: spare word write leaves neighbours intact and reads zero
    wr(3, 6, 32'hDEAD_BEEF);
    rdChk(3, 6, "R3 spare word");
    rdChk(3, 4, "R3 neighbour intact");

    clrAll();

    // R4 / R11: size sweep on window 3
    for (int s = 0; s < 64; s++) begin
      logic [63:0] b;
      b = 64'h1234_5678_9ABC_DE00;
      cfg(3, b, 6'(s), 64'hFEDC_BA98_7654_3200, 6'd7, 23'h2A5A5A);
      look(b, 1, "R4 base hits");
      look(b ^ (64'd1 << s), 1, "R4 inside window");
      if (s < 63) look(b ^ (64'd1 << (s + 1)), 0, "R4 outside window");
      else look(~b, 1, "R11 full window");
    end

    // R7 / R10: pass-through sweep on a match-all window
    for (int p = 0; p < 64; p++) begin
      cfg(3, 64'h0, 6'd63, 64'hFEDC_BA98_7654_3200, 6'(p), 23'(p * 9973));
      look(64'h0F1E_2D3C_4B5A_6978, 1, "R7 R10 substitution");
    end
    clrAll();

    // R5: zero base with nonzero size is enabled
    cfg(0, 64'h0, 6'd1, 64'hAAAA_0000_0000_1100, 6'd0, 23'h1);
    look(64'h3, 1, "R5 size-only window hits");
    look(64'h4, 0, "R8 miss");
    clrAll();

    // R6: overlap priority
    cfg(5, 64'h0000_0040_0000_0000, 6'd31, 64'h5555_0000_0000_0000, 6'd11, 23'h55);
    cfg(1, 64'h0000_0040_0000_1000, 6'd11, 64'h1111_0000_0000_0000, 6'd11, 23'h11);
    look(64'h0000_0040_0000_1ABC, 1, "R6 lower index wins");
    look(64'h0000_0040_0000_2ABC, 1, "R6 only upper window");
    look(64'h0000_0041_0000_2ABC, 0, "R8 miss zeros");

    // R9: one cycle latency
    @(negedge clk);
    lookupAddr = 64'h0000_0040_0000_1ABC;
    @(posedge clk);
    @(negedge clk);
    lookupAddr = 64'h0000_0099_0000_0000;
    #1;
    chk(outHit == 1 && outRegion == RW'(1), "R9 old result held", 64'(outHit), 64'h1);
    @(posedge clk);
    #1;
    chk(outHit == 0 && outAddr == 0, "R9 new result after edge", outAddr, 64'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule